// File: doc/BRIEF.md
# Loadable Shift Register with Tristate Outputs

This block is a small register of `WIDTH` stages (four by default) that either captures a parallel word or shifts its contents one place toward the last stage, with a serial bit entering the first stage. One select input picks load or shift. All updates happen on the falling edge of the clock. An asynchronous active-low reset clears every stage and takes priority over both load and shift.

The stage values leave the block through a bank of tristate drivers. An active-low enable controls these drivers. When the enable is off they float, and the register keeps loading, shifting and resetting as normal. The last stage also has its own output that is always driven. It can feed the serial input of the next register, so that several of these blocks form one longer shift chain. A plain debug view of the stages is also exposed, so that their contents can be observed while the tristate bank is floating.

Top module: `shreg_tri`

## Requirements
- R1: A low level on `rst_n_i` clears every stage at once, without waiting for a clock edge.
- R2: While `rst_n_i` is held low, falling clock edges leave all stages at zero, whatever the select and data inputs are.
- R3: With `sel_load_i` = 0, a falling edge moves stage n into stage n+1 and puts `ser_i` into stage 0 (stage n is bit n of `stages_o`).
- R4: With `sel_load_i` = 1, a falling edge copies `par_i` bit n into stage n.
- R5: Stages change only on falling edges of `clk_i`. A rising edge changes nothing.
- R6: With `oe_n_i` = 0, `q_o` bit n drives the value of stage n.
- R7: With `oe_n_i` = 1, every bit of `q_o` is high impedance. Loading and shifting continue, and the stored contents are not disturbed.
- R8: `tail_o` always equals the last stage (bit WIDTH-1), whatever the value of `oe_n_i`.
- R9: When `tail_o` of one register feeds `ser_i` of a second register on the same clock and select, the pair shifts as a single register of 2*WIDTH stages.
- R10: The first falling edge after `rst_n_i` returns high performs a normal load or shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the stages update on its falling edge |
| rst_n_i | input | 1 | Asynchronous clear, active low |
| sel_load_i | input | 1 | 1 = parallel load, 0 = shift toward the last stage |
| ser_i | input | 1 | Serial bit entering stage 0 |
| par_i | input | WIDTH | Parallel data; bit n goes to stage n |
| oe_n_i | input | 1 | Tristate output enable, active low |
| q_o | output | WIDTH | Tristate stage outputs |
| tail_o | output | 1 | Last stage, always driven, used for chaining |
| stages_o | output | WIDTH | Always-driven debug view of all stages |

## Verification
The bench tests clock edge polarity. It changes the inputs while the clock is low and confirms that the next rising edge leaves the stages untouched, so a design clocked on the rising edge would show the new data one half-cycle too early. It asserts reset in the middle of a high phase and checks the stages straight away, which catches a design that waits for an edge to clear. It toggles the enable with a value stored, which catches a design that gates the register instead of the drivers: that design would lose shifts or show the wrong value on re-enable. A two-register chain shifted through eight bits exposes a design whose tail output lags by one stage, or whose shift runs the wrong way.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_LOAD  = 1'b1
  } shreg_mode_e;
endpackage

// File: rtl/shreg_core.sv
module shreg_core
  import shreg_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  shreg_mode_e      mode_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] stages_o,
  output logic             load_evt_o,
  output logic             shift_evt_o
);

  // Move each stage one place up; the new bit enters at stage 0.
  function automatic logic [WIDTH-1:0] shift_up(input logic [WIDTH-1:0] cur,
                                                input logic             in_bit);
    return {cur[WIDTH-2:0], in_bit};
  endfunction

  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;

  always_comb begin
    case (mode_i)
      MODE_LOAD: stage_d = par_i;
      default:   stage_d = shift_up(stage_q, ser_i);
    endcase
  end

  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= '0;
    else          stage_q <= stage_d;
  end

  assign stages_o    = stage_q;
  assign load_evt_o  = rst_n_i && (mode_i == MODE_LOAD);
  assign shift_evt_o = rst_n_i && (mode_i == MODE_SHIFT);

endmodule

// File: rtl/shreg_drv.sv
module shreg_drv #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] stages_i,
  input  logic             oe_n_i,
  output logic [WIDTH-1:0] q_o,
  output logic             tail_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_buf
    assign q_o[b] = oe_n_i ? 1'bz : stages_i[b];
  end

  assign tail_o = stages_i[WIDTH-1];

endmodule

// File: rtl/shreg_tri.sv
module shreg_tri
  import shreg_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             sel_load_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             oe_n_i,
  output logic [WIDTH-1:0] q_o,
  output logic             tail_o,
  output logic [WIDTH-1:0] stages_o
);

  shreg_mode_e      mode;
  logic [WIDTH-1:0] stages;
  logic             load_evt;
  logic             shift_evt;

  assign mode = sel_load_i ? MODE_LOAD : MODE_SHIFT;

  shreg_core #(.WIDTH(WIDTH)) u_core (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .mode_i     (mode),
    .ser_i      (ser_i),
    .par_i      (par_i),
    .stages_o   (stages),
    .load_evt_o (load_evt),
    .shift_evt_o(shift_evt)
  );

  shreg_drv #(.WIDTH(WIDTH)) u_drv (
    .stages_i(stages),
    .oe_n_i  (oe_n_i),
    .q_o     (q_o),
    .tail_o  (tail_o)
  );

  assign stages_o = stages;

endmodule

// File: rtl/shreg_chk.sv
module shreg_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             sel_load_i,
  input logic             ser_i,
  input logic [WIDTH-1:0] par_i,
  input logic             oe_n_i,
  input logic [WIDTH-1:0] q_o,
  input logic             tail_o,
  input logic [WIDTH-1:0] stages_o
);

  // R4
  load_copy_chk: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    sel_load_i |=> (stages_o == $past(par_i)));

  // R3
  shift_move_chk: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    !sel_load_i |=> (stages_o == {$past(stages_o[WIDTH-2:0]), $past(ser_i)}));

  // R8
  tail_match_chk: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    tail_o == stages_o[WIDTH-1]);

  // R6
  drive_match_chk: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    !oe_n_i |-> (q_o == stages_o));

  // R2
  reset_hold_chk: assert property (@(negedge clk_i)
    !rst_n_i |-> (stages_o == '0));

endmodule

bind shreg_tri shreg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_n_i   (rst_n_i),
  .sel_load_i(sel_load_i),
  .ser_i     (ser_i),
  .par_i     (par_i),
  .oe_n_i    (oe_n_i),
  .q_o       (q_o),
  .tail_o    (tail_o),
  .stages_o  (stages_o)
);

// File: tb/test_shreg_tri.sv
module test_shreg_tri;
  localparam int W = 4;
  localparam int NVEC = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         sel = 1'b0;
  logic         ser = 1'b0;
  logic         oe_n = 1'b0;
  logic [W-1:0] par = '0;
  logic [W-1:0] par2 = '0;
  wire  [W-1:0] q;
  wire  [W-1:0] q2;
  logic         tail, tail2;
  logic [W-1:0] st, st2;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shreg_tri #(.WIDTH(W)) i_shreg_tri (
    .clk_i(clk), .rst_n_i(rst_n), .sel_load_i(sel), .ser_i(ser),
    .par_i(par), .oe_n_i(oe_n), .q_o(q), .tail_o(tail), .stages_o(st)
  );

  // Second register fed from the first one's tail (R9)
  shreg_tri #(.WIDTH(W)) i_shreg_tri_b (
    .clk_i(clk), .rst_n_i(rst_n), .sel_load_i(sel), .ser_i(tail),
    .par_i(par2), .oe_n_i(oe_n), .q_o(q2), .tail_o(tail2), .stages_o(st2)
  );

  // Fields: sel, ser, oe_n, par[3:0], expected stages[3:0]
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 4'b1010, 4'b1010},
    {1'b0, 1'b1, 1'b0, 4'b0000, 4'b0101},
    {1'b0, 1'b0, 1'b0, 4'b1111, 4'b1010},
    {1'b0, 1'b1, 1'b1, 4'b0000, 4'b0101},
    {1'b1, 1'b0, 1'b1, 4'b0011, 4'b0011},
    {1'b0, 1'b1, 1'b0, 4'b0000, 4'b0111},
    {1'b0, 1'b1, 1'b0, 4'b0000, 4'b1111},
    {1'b1, 1'b1, 1'b0, 4'b1000, 4'b1000},
    {1'b0, 1'b0, 1'b0, 4'b0110, 4'b0000}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic d, input logic o, input logic [W-1:0] p);
    @(posedge clk); #2;
    sel = s; ser = d; oe_n = o; par = p;
  endtask

  task automatic tick();
    @(negedge clk); #2;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] model;
    #1 rst_n = 1'b0;
    #30;
    check("R1 reset state", {4'b0, st}, 8'h00);
    check("R8 reset tail", {7'b0, tail}, 8'h00);
    @(posedge clk); #2 rst_n = 1'b1;

    // Table walk: R3 R4 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
      tick();
      check("R3/R4 stages", {4'b0, st}, {4'b0, VEC[i][3:0]});
      check("R8 tail", {7'b0, tail}, {7'b0, VEC[i][3]});
      if (!VEC[i][8])
        check("R6 driven output", {4'b0, q}, {4'b0, VEC[i][3:0]});
      else if (VEC[i][3:0] != 4'b0000)
        check("R7 floating output", {7'b0, q !== VEC[i][3:0]}, 8'h01);
    end

    // R5: inputs change while clock low; rising edge must not update
    @(negedge clk); #2;
    sel = 1'b1; par = 4'b1001; oe_n = 1'b0;
    @(posedge clk); #2;
    check("R5 no rise update", {4'b0, st}, 8'h00);
    tick();
    check("R5 fall update", {4'b0, st}, 8'h09);

    // R1: asynchronous clear in the middle of a high phase
    drive(1'b1, 1'b0, 1'b0, 4'b1111);
    tick();
    check("R4 load ones", {4'b0, st}, 8'h0F);
    @(posedge clk); #3 rst_n = 1'b0;
    #1;
    check("R1 async clear", {4'b0, st}, 8'h00);
    check("R1 tail cleared", {7'b0, tail}, 8'h00);
    tick();
    tick();
    check("R2 reset holds", {4'b0, st}, 8'h00);

    // R10: first falling edge after release works
    par = 4'b0110;
    @(posedge clk); #2 rst_n = 1'b1;
    tick();
    check("R10 first edge load", {4'b0, st}, 8'h06);

    // R7: shifting continues while disabled, contents survive re-enable
    drive(1'b0, 1'b1, 1'b1, 4'b0000);
    tick();
    check("R7 shift while off", {4'b0, st}, 8'h0D);
    check("R8 tail while off", {7'b0, tail}, 8'h01);
    check("R7 floating", {7'b0, q !== 4'b1101}, 8'h01);
    oe_n = 1'b0;
    #1;
    check("R6 re-enable", {4'b0, q}, 8'h0D);

    // R9: two chained registers shift eight bits
    drive(1'b1, 1'b0, 1'b0, 4'b0000);
    par2 = 4'b0000;
    tick();
    model = 8'h00;
    check("R9 chain cleared", {st2, st}, model);
    for (int k = 0; k < 8; k++) begin
      logic b;
      b = (8'b1101_0010 >> k) & 8'h01;
      drive(1'b0, b, 1'b0, 4'b0000);
      tick();
      model = {model[6:0], b};
      check("R9 chain shift", {st2, st}, model);
    end
    check("R9 chain tail", {7'b0, tail2}, {7'b0, model[7]});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule